// File: doc/BRIEF.md
# Selectable Event Performance Counters

This block is a profiling unit. It holds a free-running 64-bit cycle counter and two 64-bit event counters. Each event counter is steered by its own 16-bit selector. The selector picks one of 64 event lines, decides in which privilege rings counting is allowed, and chooses between two modes. In one mode the counter adds one for every cycle in which the selected pulse line is high. In the other it adds one for every cycle in which the selected busy line is high.

Software reaches the unit through a single-cycle indexed register port. Index 0x10 reads the cycle count. Index 0x11 holds both selectors packed into 32 bits. Indices 0x12 and 0x13 are the two event counters. The selectors stay in place across reads, so software measures an interval by reading a counter twice and subtracting the two values. Any other index is an illegal access.

Top module: `perf_event_counters`

## Requirements
- R1: After reset all registers read zero. The cycle counter at index 0x10 advances by exactly one on every clock edge while reset is released.
- R2: Bits 15:0 of the select register at index 0x11 steer the counter at index 0x12, and bits 31:16 steer the counter at index 0x13. A write to index 0x11 stores acc_wdata[31:0]. A read returns the stored value in bits 31:0, with bits 63:32 reading zero.
- R3: Within a selector, bits 5:0 give the number (0 to 63) of the event line that the counter follows.
- R4: Selector bit 6 allows counting while priv_ring is 0, 1 or 2. Selector bit 7 allows counting while priv_ring is 3. When the allowing bit for the current ring is clear, the counter holds.
- R5: Selector bit 8 chooses the mode. With 0, the counter adds one in each cycle where evt_pulse of the chosen line is 1. With 1, it adds one in each cycle where evt_busy of the chosen line is 1.
- R6: Selector bits 15:9 are stored and read back unchanged, and they have no effect on counting.
- R7: A write to index 0x12 or 0x13 loads acc_wdata into that counter, and the load takes precedence over a count in the same cycle. A select write takes effect on counting from the cycle after the write.
- R8: Counters wrap modulo 2^64. All ones plus one gives zero.
- R9: An access with an index outside 0x10 to 0x13 sets acc_err for exactly the next cycle, makes rd_data zero in that cycle, and changes no register.
- R10: rd_data shows, in the cycle after a legal read, the register value as it stood in the request cycle. In every other cycle rd_data is zero. A write to index 0x10 has no effect on the cycle count.
- R11: Reads do not disturb counting, so back-to-back reads return a consistent series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 64 | One bit per event line, high in a cycle where the event occurs |
| evt_busy | input | 64 | One bit per event line, high while the event is being processed |
| priv_ring | input | 2 | Current privilege ring, 0 to 3 |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | 8 | Register index |
| acc_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid the cycle after a legal read, otherwise zero |
| acc_err | output | 1 | One-cycle flag for an illegal index |

## Verification
A wrong selector field shows up as a counter that diverges from the reference within the first cycle the wrong event or ring gate differs. It becomes visible at the next read of that counter, which the bench issues every few tens of cycles. A corrupted select register is exposed by its next readback. Faults in the read path or the error flag appear on rd_data or acc_err one cycle after the offending request, because both outputs are compared on every clock.

// File: rtl/perf_pkg.sv
// Shared constants and the selector field layout for the profiling unit.
// Assumes a 16-bit selector with the event number in the low bits.
package perf_pkg;

    localparam int SEL_W       = 16;
    localparam int EVT_FIELD_W = 6;
    localparam int IDX_CYC     = 'h10;
    localparam int IDX_SEL     = 'h11;
    localparam int IDX_CNT0    = 'h12;

    typedef struct packed {
        logic [6:0]             rsvd;     // kept, no function
        logic                   busy_mode;// 1 = busy cycles, 0 = pulses
        logic                   user_en;  // ring 3
        logic                   sys_en;   // rings 0..2
        logic [EVT_FIELD_W-1:0] evt;      // event line number
    } sel_t;

endpackage

// File: rtl/perf_counter.sv
// Wide counter with a synchronous load that overrides the increment.
// Assumes the load value is already at counter width; wraps modulo 2^W.
module perf_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Counter state: reset, load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/perf_event_select.sv
// Picks one event line per selector and applies the ring filter and mode.
// Assumes event numbers at or above NUM_EVENTS never fire.
module perf_event_select
    import perf_pkg::*;
#(
    parameter int NUM_EVENTS = 64
) (
    input  logic [NUM_EVENTS-1:0]  evt_pulse,
    input  logic [NUM_EVENTS-1:0]  evt_busy,
    input  logic [1:0]             priv_ring,
    input  logic [EVT_FIELD_W-1:0] evt_num,
    input  logic                   busy_mode,
    input  logic                   sys_en,
    input  logic                   user_en,
    output logic                   inc
);

    localparam int SPAN = 1 << EVT_FIELD_W;

    logic [SPAN-1:0] pulse_pad;
    logic [SPAN-1:0] busy_pad;
    logic            hit;
    logic            ring_ok;

    // Widen the event vectors so any selector value indexes safely.
    always_comb begin
        pulse_pad = SPAN'(evt_pulse);
        busy_pad  = SPAN'(evt_busy);
    end

    // Count qualifier: selected line in the chosen mode, gated by ring.
    always_comb begin
        hit     = busy_mode ? busy_pad[evt_num] : pulse_pad[evt_num];
        ring_ok = (priv_ring == 2'd3) ? user_en : sys_en;
        inc     = hit & ring_ok;
    end

endmodule

// File: rtl/perf_access_port.sv
// Indexed register port: decodes the index, owns the select register,
// raises load strobes and registers read data and the error flag.
// Assumes DATA_W covers both the counters and the packed selectors.
module perf_access_port
    import perf_pkg::*;
#(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 64,
    parameter int DATA_W  = 64,
    parameter int IDX_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_valid,
    input  logic                           acc_write,
    input  logic [IDX_W-1:0]               acc_index,
    input  logic [DATA_W-1:0]              acc_wdata,
    input  logic [CNT_W-1:0]               cyc,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt,
    output logic [NUM_CNT*SEL_W-1:0]       sel,
    output logic [NUM_CNT-1:0]             load,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           acc_err
);

    localparam int              SELR_W = NUM_CNT * SEL_W;
    localparam logic [IDX_W-1:0] A_CYC = IDX_W'(IDX_CYC);
    localparam logic [IDX_W-1:0] A_SEL = IDX_W'(IDX_SEL);
    localparam logic [IDX_W-1:0] A_C0  = IDX_W'(IDX_CNT0);
    localparam logic [IDX_W-1:0] A_CE  = IDX_W'(IDX_CNT0 + NUM_CNT);

    logic              legal;
    logic              sel_we;
    logic [DATA_W-1:0] rd_next;
    logic              err_next;

    // Index decode, write strobes and read mux for this cycle's request.
    always_comb begin
        legal    = (acc_index == A_CYC) || (acc_index == A_SEL) ||
                   ((acc_index >= A_C0) && (acc_index < A_CE));
        rd_next  = '0;
        err_next = 1'b0;
        sel_we   = 1'b0;
        load     = '0;
        if (acc_valid) begin
            if (!legal) begin
                err_next = 1'b1;
            end else if (acc_write) begin
                sel_we = (acc_index == A_SEL);
                for (int k = 0; k < NUM_CNT; k++)
                    load[k] = (acc_index == IDX_W'(IDX_CNT0 + k));
            end else begin
                if (acc_index == A_CYC) rd_next = DATA_W'(cyc);
                if (acc_index == A_SEL) rd_next = DATA_W'(sel);
                for (int k = 0; k < NUM_CNT; k++)
                    if (acc_index == IDX_W'(IDX_CNT0 + k))
                        rd_next = DATA_W'(cnt[k]);
            end
        end
    end

    // Packed selector register, written whole from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= '0;
        else if (sel_we) sel <= acc_wdata[SELR_W-1:0];
    end

    // Registered response: data or zero, plus the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            acc_err <= 1'b0;
        end else begin
            rd_data <= rd_next;
            acc_err <= err_next;
        end
    end

endmodule

// File: rtl/perf_event_counters.sv
// Top of the profiling unit: cycle counter, NUM_CNT selectable event
// counters and the indexed register port that reaches them.
// Assumes events are sampled synchronously to clk.
module perf_event_counters
    import perf_pkg::*;
#(
    parameter int NUM_EVENTS = 64,
    parameter int NUM_CNT    = 2,
    parameter int CNT_W      = 64,
    parameter int DATA_W     = 64,
    parameter int IDX_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_pulse,
    input  logic [NUM_EVENTS-1:0] evt_busy,
    input  logic [1:0]            priv_ring,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [IDX_W-1:0]      acc_index,
    input  logic [DATA_W-1:0]     acc_wdata,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  acc_err
);

    logic [CNT_W-1:0]              cyc_q;
    logic [NUM_CNT*SEL_W-1:0]      sel_q;
    logic [NUM_CNT-1:0]            load_vec;
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus;

    perf_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .inc      (1'b1),
        .cnt      (cyc_q)
    );

    perf_access_port #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_index (acc_index),
        .acc_wdata (acc_wdata),
        .cyc       (cyc_q),
        .cnt       (cnt_bus),
        .sel       (sel_q),
        .load      (load_vec),
        .rd_data   (rd_data),
        .acc_err   (acc_err)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        sel_t cfg;

        // Slice this counter's selector out of the packed register.
        always_comb cfg = sel_t'(sel_q[g*SEL_W +: SEL_W]);

        perf_event_select #(.NUM_EVENTS(NUM_EVENTS)) u_sel (
            .evt_pulse (evt_pulse),
            .evt_busy  (evt_busy),
            .priv_ring (priv_ring),
            .evt_num   (cfg.evt),
            .busy_mode (cfg.busy_mode),
            .sys_en    (cfg.sys_en),
            .user_en   (cfg.user_en),
            .inc       (inc_vec[g])
        );

        perf_counter #(.W(CNT_W)) u_evt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_vec[g]),
            .load_val (acc_wdata[CNT_W-1:0]),
            .inc      (inc_vec[g]),
            .cnt      (cnt_bus[g])
        );
    end

endmodule

// File: rtl/perf_event_counters_chk.sv
// Property checker for the profiling unit, bound onto the top module.
// Assumes the default two counters at indices 0x12 and 0x13.
module perf_event_counters_chk #(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [IDX_W-1:0]  acc_index,
    input logic [1:0]        priv_ring,
    input logic [DATA_W-1:0] rd_data,
    input logic              acc_err,
    input logic [CNT_W-1:0]  cyc,
    input logic [31:0]       sel,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1
);

    logic pv;
    logic idx_ok;
    logic wr0;
    logic wr1;
    logic gate0;
    logic gate1;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    // Port-level views used by the properties.
    always_comb begin
        idx_ok = (acc_index >= IDX_W'('h10)) && (acc_index <= IDX_W'('h13));
        wr0    = acc_valid && acc_write && (acc_index == IDX_W'('h12));
        wr1    = acc_valid && acc_write && (acc_index == IDX_W'('h13));
        gate0  = (priv_ring == 2'd3) ? sel[7]  : sel[6];
        gate1  = (priv_ring == 2'd3) ? sel[23] : sel[22];
    end

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pv |-> cyc == $past(cyc) + CNT_W'(1)); // R1

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> rd_data == '0); // R9

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && acc_err) |-> $past(acc_valid && !idx_ok)); // R9

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && !$past(acc_valid)) |-> (rd_data == '0 && !acc_err)); // R10

    AST_CNT0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && !$past(wr0)) |->
        (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1))); // R8

    AST_RING_GATE0: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(!wr0 && !gate0)) |-> cnt0 == $past(cnt0)); // R4

    AST_RING_GATE1: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(!wr1 && !gate1)) |-> cnt1 == $past(cnt1)); // R4

endmodule

bind perf_event_counters perf_event_counters_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_index (acc_index),
    .priv_ring (priv_ring),
    .rd_data   (rd_data),
    .acc_err   (acc_err),
    .cyc       (cyc_q),
    .sel       (sel_q[31:0]),
    .cnt0      (cnt_bus[0]),
    .cnt1      (cnt_bus[1])
);

// File: tb/perf_event_counters_tb.sv
// Bench: behavioural reference model stepped on each rising edge, with
// both outputs compared against it on every falling edge.
module perf_event_counters_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt_pulse = '0;
    logic [63:0] evt_busy = '0;
    logic [1:0]  priv_ring = 2'd0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_index = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] rd_data;
    logic        acc_err;

    int    checks = 0;
    int    errors = 0;
    bit    ev_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // reference model state
    logic [63:0] m_cyc;
    logic [31:0] m_sel;
    logic [63:0] m_cnt [2];
    logic [63:0] e_rd;
    logic        e_err;

    always #2.5 clk = ~clk;

    perf_event_counters u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .evt_busy  (evt_busy),
        .priv_ring (priv_ring),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_index (acc_index),
        .acc_wdata (acc_wdata),
        .rd_data   (rd_data),
        .acc_err   (acc_err)
    );

    // Reference model, evaluated from the inputs held stable since the
    // preceding falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_sel = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            e_rd = 0; e_err = 0;
        end else begin
            e_rd = 0; e_err = 0;
            if (acc_valid) begin
                if (acc_index < 8'h10 || acc_index > 8'h13) e_err = 1;
                else if (!acc_write) begin
                    case (acc_index)
                        8'h10:   e_rd = m_cyc;
                        8'h11:   e_rd = {32'h0, m_sel};
                        8'h12:   e_rd = m_cnt[0];
                        default: e_rd = m_cnt[1];
                    endcase
                end
            end
            for (int i = 0; i < 2; i++) begin
                logic [15:0] s;
                logic hit, ok;
                s   = m_sel[16*i +: 16];
                hit = s[8] ? evt_busy[s[5:0]] : evt_pulse[s[5:0]];
                ok  = (priv_ring == 2'd3) ? s[7] : s[6];
                if (acc_valid && acc_write && acc_index == 8'(8'h12 + i))
                    m_cnt[i] = acc_wdata;
                else if (hit && ok)
                    m_cnt[i] = m_cnt[i] + 64'd1;
            end
            if (acc_valid && acc_write && acc_index == 8'h11)
                m_sel = acc_wdata[31:0];
            m_cyc = m_cyc + 64'd1;
        end
    end

    // Compare both outputs against the model away from the rising edge.
    always @(negedge clk) begin
        checks++;
        if (rd_data !== e_rd) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", cur_tag, rd_data, e_rd);
        end
        checks++;
        if (acc_err !== e_err) begin
            errors++;
            $display("FAIL %s acc_err actual %b expected %b", cur_tag, acc_err, e_err);
        end
    end

    // Random event traffic when enabled.
    always @(negedge clk) begin
        if (ev_on) begin
            evt_pulse = {$urandom, $urandom};
            evt_busy  = {$urandom, $urandom};
        end
    end

    task automatic acc(input bit w, input logic [7:0] i, input logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_index = i; acc_wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = 1'b0; acc_write = 1'b0;
        end
    endtask

    task automatic read_all();
        acc(0, 8'h10, 0); acc(0, 8'h11, 0); acc(0, 8'h12, 0); acc(0, 8'h13, 0);
        idle(2);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        // R1: reset state, then cycle counter progress
        cur_tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        read_all();
        idle(5);
        acc(0, 8'h10, 0); idle(2);

        // R2 R6: packed selectors with reserved bits set, upper data ignored
        cur_tag = "R2/R6";
        acc(1, 8'h11, 64'hDEAD_BEEF_FE45_0143);
        acc(0, 8'h11, 0); idle(2);

        // R3 R5: busy mode on line 3 and pulse mode on line 5
        cur_tag = "R3/R5";
        ev_on = 1'b1;
        idle(40); read_all();
        acc(1, 8'h11, 64'h0000_0000_01CA_00FF);
        idle(30); read_all();

        // R4: ring gating across all rings
        cur_tag = "R4";
        acc(1, 8'h11, 64'h0000_0000_0047_0141);
        priv_ring = 2'd3; idle(20); read_all();
        priv_ring = 2'd1; idle(20); read_all();
        acc(1, 8'h11, 64'h0000_0000_0087_0181);
        idle(20); read_all();
        priv_ring = 2'd3; idle(20); read_all();
        priv_ring = 2'd2; idle(10); read_all();

        // R7: counter loads and select change timing
        cur_tag = "R7";
        acc(1, 8'h12, 64'h0123_4567_89AB_CDEF);
        acc(1, 8'h13, 64'h8000_0000_0000_0000);
        acc(0, 8'h12, 0); acc(0, 8'h13, 0);
        acc(1, 8'h11, 64'h0000_0000_00C2_01C4);
        acc(0, 8'h12, 0); acc(0, 8'h13, 0); idle(2);

        // R8: wrap through all ones
        cur_tag = "R8";
        ev_on = 1'b0;
        @(negedge clk); evt_pulse = '0; evt_busy = '1;
        acc(1, 8'h11, 64'h0000_0000_00C0_01C0);
        acc(1, 8'h12, 64'hFFFF_FFFF_FFFF_FFFE);
        acc(1, 8'h13, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(3); read_all();

        // R9: illegal indices, read and write, then state readback
        cur_tag = "R9";
        ev_on = 1'b1;
        acc(0, 8'h00, 0); acc(1, 8'h0F, 64'h55); acc(1, 8'h14, 64'hAA);
        acc(0, 8'hFF, 0); idle(1);
        acc(1, 8'h90, 64'h1); acc(0, 8'h11, 0); idle(2);
        read_all();

        // R10: write to the cycle index has no effect; idle response zero
        cur_tag = "R10";
        acc(1, 8'h10, 64'h0); acc(0, 8'h10, 0); idle(6);

        // R11: back-to-back reads while counting
        cur_tag = "R11";
        for (int n = 0; n < 12; n++) acc(0, 8'(8'h10 + (n % 4)), 0);
        idle(3);

        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog actual hung expected done");
            summary();
        end
    end

endmodule